// File: doc/BRIEF.md
# SPI Data-Ready Line Demultiplexer

Some delta-sigma converters use their serial data output pin for two things. It carries read data during a transfer. Between transfers, with the converter still selected, the same pin is pulled low to say that a new sample is waiting. This block sits between an SPI controller and the board pins and separates that ready indication from the data.

All controller-side SPI signals go straight to the pin side, and the pin-side MISO comes straight back, with no added delay. Alongside this path the block watches one chosen chip-select line and the controller's "transfer in progress" flag. It raises a level data-ready flag once the bus has been quiet long enough and the converter holds MISO low. The flag can drive an interrupt input or start an offload engine that reads the sample.

The quiet interval is set by a parameter. It must be longer, in clock cycles, than the converter's chip-select-to-ready delay and its post-clock output settling time. This keeps read data and settling edges from being taken as a ready indication.

Top module: `sdrdy_demux`

## Requirements
- R1: `pad_sclk`, `pad_mosi` and `pad_cs_n` equal `ctl_sclk`, `ctl_mosi` and `ctl_cs_n` combinationally, bit for bit, at all times, including during reset.
- R2: `ctl_miso` equals `pad_miso` combinationally at all times.
- R3: The bus is "quiet" on a clock edge when bit CS_PIN of `ctl_cs_n` is 0 (chip-selects are active low) and `xfer_busy` is 0. `rdy` can be 1 after an edge only if the bus was quiet on that edge and on the IDLE_TIMEOUT edges before it, which is IDLE_TIMEOUT+1 consecutive quiet edges in all.
- R4: An edge on which the bus is not quiet, because the watched chip-select is 1 or `xfer_busy` is 1, forces `rdy` to 0 after that edge and restarts the quiet count from zero.
- R5: Once the quiet count is complete, `rdy` after an edge is the inverse of `pad_miso` as sampled two edges earlier. MISO passes through a two-flop synchroniser whose flops reset to 1, so a low MISO reads as ready.
- R6: `rdy` is a level. It stays 1 for as long as the bus stays quiet and the synchronised MISO stays low.
- R7: Chip-select bits other than CS_PIN have no effect on `rdy`.
- R8: The quiet counter saturates at IDLE_TIMEOUT and never wraps, so an idle period of any length keeps the detector armed.
- R9: `rst_n` is active low and clears `rdy` and all detector state at once, asynchronously. Release is synchronised: the first edge that counts toward the quiet interval is the third rising edge after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| xfer_busy | input | 1 | High while the controller runs a transfer |
| ctl_sclk | input | 1 | Serial clock from the controller |
| ctl_mosi | input | 1 | Serial data from the controller |
| ctl_cs_n | input | NUM_CS | Active-low chip-selects from the controller |
| ctl_miso | output | 1 | Serial data returned to the controller |
| pad_sclk | output | 1 | Serial clock to the pins |
| pad_mosi | output | 1 | Serial data to the pins |
| pad_cs_n | output | NUM_CS | Chip-selects to the pins |
| pad_miso | input | 1 | Shared data / ready line from the pins |
| rdy | output | 1 | Level data-ready flag, active high |

## Verification
Two functions can act on `rdy` in the same cycle. One is a bus break: the watched chip-select rises or `xfer_busy` rises. The other is the MISO path, where a low level is arriving from the synchroniser. The bench provokes this collision by dropping MISO and starting a transfer within the same few cycles, both in directed steps and under random toggling of all inputs. A reference model written from the requirements is updated on every edge and gives the expected `rdy`. The break must always win on the following edge, and detection must then wait out a full fresh quiet interval.

// File: rtl/sdrdy_pkg.sv
package sdrdy_pkg;
  // Width needed to hold values 0..max_val.
  function automatic int unsigned cnt_width(input int unsigned max_val);
    int unsigned w;
    w = 1;
    while ((64'd1 << w) <= 64'(max_val)) w++;
    return w;
  endfunction

  typedef enum logic [1:0] {
    DET_BROKEN = 2'd0,
    DET_COUNT  = 2'd1,
    DET_ARMED  = 2'd2
  } det_state_e;
endpackage

// File: rtl/sdrdy_rst_sync.sv
module sdrdy_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sdrdy_bit_sync.sv
module sdrdy_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      logic stage_d;
      if (gi == 0) begin : g_first
        assign stage_d = d;
      end else begin : g_next
        assign stage_d = stage_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= RST_VAL;
        else        stage_q[gi] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sdrdy_idle_timer.sv
module sdrdy_idle_timer
  import sdrdy_pkg::*;
#(
  parameter int IDLE_TIMEOUT = 63
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       quiet,
  output logic       armed,
  output det_state_e state
);
  localparam int unsigned CW = cnt_width(IDLE_TIMEOUT);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_TIMEOUT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (!quiet)              cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign armed = (cnt_q == LIMIT);

  always_comb begin
    if (!quiet)     state = DET_BROKEN;
    else if (armed) state = DET_ARMED;
    else            state = DET_COUNT;
  end
endmodule

// File: rtl/sdrdy_demux.sv
module sdrdy_demux
  import sdrdy_pkg::*;
#(
  parameter int NUM_CS       = 2,
  parameter int CS_PIN       = 0,
  parameter int IDLE_TIMEOUT = 63,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_busy,
  input  logic              ctl_sclk,
  input  logic              ctl_mosi,
  input  logic [NUM_CS-1:0] ctl_cs_n,
  output logic              ctl_miso,
  output logic              pad_sclk,
  output logic              pad_mosi,
  output logic [NUM_CS-1:0] pad_cs_n,
  input  logic              pad_miso,
  output logic              rdy
);
  // Pass-through path, no registers.
  assign pad_sclk = ctl_sclk;
  assign pad_mosi = ctl_mosi;
  assign pad_cs_n = ctl_cs_n;
  assign ctl_miso = pad_miso;

  logic       rst_n_int;
  logic       miso_sync;
  logic       quiet;
  logic       armed;
  det_state_e det_state;
  logic       rdy_d;
  logic       rdy_q;

  sdrdy_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sdrdy_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_miso_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     (pad_miso),
    .q     (miso_sync)
  );

  assign quiet = ~ctl_cs_n[CS_PIN] & ~xfer_busy;

  sdrdy_idle_timer #(.IDLE_TIMEOUT(IDLE_TIMEOUT)) u_timer (
    .clk   (clk),
    .rst_n (rst_n_int),
    .quiet (quiet),
    .armed (armed),
    .state (det_state)
  );

  always_comb begin
    rdy_d = (det_state == DET_ARMED) & armed & ~miso_sync;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) rdy_q <= 1'b0;
    else            rdy_q <= rdy_d;
  end

  assign rdy = rdy_q;
endmodule

// File: rtl/sdrdy_demux_chk.sv
module sdrdy_demux_chk #(
  parameter int NUM_CS       = 2,
  parameter int CS_PIN       = 0,
  parameter int IDLE_TIMEOUT = 63
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_busy,
  input logic              ctl_sclk,
  input logic              ctl_mosi,
  input logic [NUM_CS-1:0] ctl_cs_n,
  input logic              ctl_miso,
  input logic              pad_sclk,
  input logic              pad_mosi,
  input logic [NUM_CS-1:0] pad_cs_n,
  input logic              pad_miso,
  input logic              rdy
);
  localparam int QW = $clog2(IDLE_TIMEOUT + 2);
  localparam logic [QW-1:0] QMAX = QW'(IDLE_TIMEOUT + 1);

  logic          bus_quiet;
  logic [QW-1:0] qrun;

  assign bus_quiet = (ctl_cs_n[CS_PIN] == 1'b0) && !xfer_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           qrun <= '0;
    else if (!bus_quiet)  qrun <= '0;
    else if (qrun != QMAX) qrun <= qrun + 1'b1;
  end

  p_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pad_sclk == ctl_sclk && pad_mosi == ctl_mosi && pad_cs_n == ctl_cs_n);

  p_miso_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_miso == pad_miso);

  p_quiet_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> qrun == QMAX);

  p_break_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_quiet |=> !rdy);

  p_miso_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> !$past(pad_miso, 3));

  p_level_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdy && bus_quiet && !$past(pad_miso, 2) |=> rdy);

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !rdy);
endmodule

bind sdrdy_demux sdrdy_demux_chk #(
  .NUM_CS(NUM_CS), .CS_PIN(CS_PIN), .IDLE_TIMEOUT(IDLE_TIMEOUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_busy(xfer_busy), .ctl_sclk(ctl_sclk),
  .ctl_mosi(ctl_mosi), .ctl_cs_n(ctl_cs_n), .ctl_miso(ctl_miso),
  .pad_sclk(pad_sclk), .pad_mosi(pad_mosi), .pad_cs_n(pad_cs_n),
  .pad_miso(pad_miso), .rdy(rdy)
);

// File: tb/sdrdy_demux_bench.sv
module sdrdy_demux_bench;
  localparam int CLK_P   = 10;
  localparam int TB_NCS  = 3;
  localparam int TB_PIN  = 1;
  localparam int TB_IDLE = 12;
  localparam int RAND_TICKS = 20000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              xfer_busy;
  logic              ctl_sclk;
  logic              ctl_mosi;
  logic [TB_NCS-1:0] ctl_cs_n;
  logic              ctl_miso;
  logic              pad_sclk;
  logic              pad_mosi;
  logic [TB_NCS-1:0] pad_cs_n;
  logic              pad_miso;
  logic              rdy;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  sdrdy_demux #(
    .NUM_CS(TB_NCS), .CS_PIN(TB_PIN), .IDLE_TIMEOUT(TB_IDLE)
  ) u_sdrdy_demux (
    .clk(clk), .rst_n(rst_n), .xfer_busy(xfer_busy), .ctl_sclk(ctl_sclk),
    .ctl_mosi(ctl_mosi), .ctl_cs_n(ctl_cs_n), .ctl_miso(ctl_miso),
    .pad_sclk(pad_sclk), .pad_mosi(pad_mosi), .pad_cs_n(pad_cs_n),
    .pad_miso(pad_miso), .rdy(rdy)
  );

  // Reference model built from R3, R4, R5, R8, R9.
  bit m_rs1, m_rs2, m_s1, m_s2, m_rdy;
  int m_cnt;

  function automatic bit quiet_now(input logic [TB_NCS-1:0] cs, input logic busy);
    return (cs[TB_PIN] == 1'b0) && (busy == 1'b0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_s1 = 1; m_s2 = 1; m_cnt = 0; m_rdy = 0;
    end else begin
      if (!m_rs2) begin
        m_s1 = 1; m_s2 = 1; m_cnt = 0; m_rdy = 0;
      end else begin
        m_rdy = quiet_now(ctl_cs_n, xfer_busy) && (m_cnt == TB_IDLE) && !m_s2;
        if (!quiet_now(ctl_cs_n, xfer_busy)) m_cnt = 0;
        else if (m_cnt < TB_IDLE) m_cnt = m_cnt + 1;
        m_s2 = m_s1;
        m_s1 = pad_miso;
      end
      m_rs2 = m_rs1;
      m_rs1 = 1;
    end
  end

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic check_pass();
    checks++;
    if (pad_sclk !== ctl_sclk || pad_mosi !== ctl_mosi || pad_cs_n !== ctl_cs_n) begin
      failures++;
      $display("FAIL R1 actual=%b%b%b expected=%b%b%b", pad_sclk, pad_mosi, pad_cs_n,
               ctl_sclk, ctl_mosi, ctl_cs_n);
    end
    checks++;
    if (ctl_miso !== pad_miso) begin
      failures++;
      $display("FAIL R2 actual=%b expected=%b", ctl_miso, pad_miso);
    end
  endtask

  // One clock: sample after the rising edge against the model, return at the falling edge.
  task automatic tick(input string tag);
    @(posedge clk);
    #(CLK_P/4);
    check_bit(tag, rdy, m_rdy);
    check_pass();
    @(negedge clk);
  endtask

  task automatic tick_exp(input string tag, input logic exp);
    tick(tag);
    check_bit(tag, rdy, exp);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5D1A));
    rst_n = 1'b0; xfer_busy = 1'b0; ctl_sclk = 1'b1; ctl_mosi = 1'b0;
    ctl_cs_n = '1; pad_miso = 1'b1;
    #1;
    check_bit("R9 reset state", rdy, 1'b0);
    check_pass();
    @(negedge clk);
    ctl_cs_n[TB_PIN] = 1'b0; pad_miso = 1'b0;
    for (int i = 0; i < 4; i++) tick_exp("R9 held in reset", 1'b0);

    // R9/R3: first detection on tick IDLE+3 after release.
    rst_n = 1'b1;
    for (int k = 1; k <= TB_IDLE + 3; k++) tick_exp("R3 quiet interval", (k == TB_IDLE + 3));

    // R6 level, R8 long idle well past the counter range.
    for (int k = 0; k < 300; k++) tick_exp("R8 saturate", 1'b1);
    tick_exp("R6 level", 1'b1);

    // R5: MISO high reaches rdy on the third edge.
    pad_miso = 1'b1;
    tick_exp("R5 miso high 1", 1'b1);
    tick_exp("R5 miso high 2", 1'b1);
    tick_exp("R5 miso high 3", 1'b0);
    pad_miso = 1'b0;
    tick_exp("R5 miso low 1", 1'b0);
    tick_exp("R5 miso low 2", 1'b0);
    tick_exp("R5 miso low 3", 1'b1);

    // R4: transfer starts, then a full fresh interval is needed.
    xfer_busy = 1'b1;
    tick_exp("R4 busy clears", 1'b0);
    xfer_busy = 1'b0;
    for (int k = 1; k <= TB_IDLE + 1; k++) tick_exp("R4 restart", (k == TB_IDLE + 1));

    // R7: other chip-selects toggle freely.
    for (int k = 0; k < 30; k++) begin
      for (int b = 0; b < TB_NCS; b++) if (b != TB_PIN) ctl_cs_n[b] = 1'($urandom);
      ctl_sclk = 1'($urandom); ctl_mosi = 1'($urandom);
      tick_exp("R7 other cs ignored", 1'b1);
    end
    ctl_cs_n[TB_PIN] = 1'b1;
    tick_exp("R4 watched cs deasserts", 1'b0);
    ctl_cs_n[TB_PIN] = 1'b0;

    // Collision: MISO falls and a transfer begins together.
    pad_miso = 1'b1;
    for (int k = 0; k < TB_IDLE + 4; k++) tick("R5 prep");
    pad_miso = 1'b0; xfer_busy = 1'b1;
    tick_exp("R4 collision", 1'b0);
    xfer_busy = 1'b0;
    for (int k = 1; k <= TB_IDLE + 1; k++) tick_exp("R3 after collision", (k == TB_IDLE + 1));

    // Random phase against the model.
    for (int n = 0; n < RAND_TICKS; n++) begin
      if (xfer_busy) begin
        if ($urandom % 100 < 30) xfer_busy = 1'b0;
      end else if ($urandom % 1000 < 15) xfer_busy = 1'b1;
      if ($urandom % 1000 < 8) ctl_cs_n[TB_PIN] = ~ctl_cs_n[TB_PIN];
      for (int b = 0; b < TB_NCS; b++) if (b != TB_PIN && ($urandom % 10 == 0)) ctl_cs_n[b] = ~ctl_cs_n[b];
      if ($urandom % 100 < 6) pad_miso = ~pad_miso;
      ctl_sclk = 1'($urandom); ctl_mosi = 1'($urandom);
      rst_n = (n >= 9000 && n < 9003) ? 1'b0 : 1'b1;
      tick("R5 random model");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule